// File: doc/BRIEF.md
# Two-Way Set-Associative Read Cache

This block is a small read-only cache sitting between a requester and a read-only backing memory. The address is 7 bits and the word is 2 bits. The cache holds 16 lines. They are arranged as 8 sets of 2 ways, and each way keeps one word per line. Each way has its own single-port storage array. Set n occupies entry n of both arrays. An entry carries a recency bit, a valid flag, a 4-bit tag and the 2-bit word.

An access always takes two cycles.
- **Accept cycle.** The block accepts the request and reads both ways of the addressed set.
- **Response cycle.** The block compares the tags and presents the word. It then writes both entries of the set back in that same cycle. The write refreshes the recency bits even on a hit, because a single-port array cannot be read and written in one cycle.
- **Miss.** On a miss, the fetch from backing memory is merged into the response cycle. The requested word is passed straight to the output and written into the chosen way at the same time.

Top module: `assoc_cache`

## Requirements
- R1: After reset, `reqReady` is 1, `respValid` is 0 and `memRead` is 0, and every line is invalid, so the first access to any address misses.
- R2: A request is taken when `reqValid` and `reqReady` are both 1. `respValid` is then 1 in the next cycle and only that cycle. `reqReady` is 0 during that response cycle and returns to 1 in the cycle after it, for hits and misses alike.
- R3: The set index is address bits [2:0] and the tag is address bits [6:3]. A request hits when a valid way of its set holds its tag. On a hit, `respHit` is 1 and `respData` is the stored word.
- R4: On a miss, `memRead` is 1 during the response cycle and `memAddr` equals the request address. `respHit` is 0, and `respData` equals `memData` from that same cycle.
- R5: A miss fills an invalid way of its set before any valid one, so two different tags of one set can both be resident.
- R6: When both ways of a set are valid, a miss replaces the way used least recently. Use counts both hits and fills.
- R7: A hit refreshes recency. After tags A then B are filled, a hit on A followed by a miss on C evicts B, not A.
- R8: `memRead` is 0 whenever no miss response is under way, including on hits and in idle cycles.
- R9: Activity in one set leaves the contents of every other set unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Read request present |
| reqAddr | input | 7 | Requested word address |
| reqReady | output | 1 | Cache can take a request this cycle |
| respValid | output | 1 | Response cycle of an access |
| respHit | output | 1 | The access found the word in the cache |
| respData | output | 2 | Returned word |
| memRead | output | 1 | Backing memory read strobe (miss) |
| memAddr | output | 7 | Backing memory address |
| memData | input | 2 | Backing memory word, same-cycle return |

## Verification
The first pattern is a scripted sequence within one set. Repeated tags, a second tag, a hit that reorders recency, and a third tag together separate fill-invalid-first from true least-recent replacement. They also separate "recency updated on hits" from "recency updated only on fills". Accesses to other sets are interleaved with that sequence to show that neighbouring sets are isolated. A long pseudo-random stream over a small pool of addresses then stresses eviction chains, with tags per set above the way count. The backing memory returns a word that differs between tags of one set, so a hit served from the wrong way shows up as bad data.

// File: rtl/assoc_cache_pkg.sv
package assoc_cache_pkg;
  parameter int ADDR_W = 7;
  parameter int DATA_W = 2;
  parameter int WAYS   = 2;
  parameter int LINES  = 16;
  localparam int SETS  = LINES / WAYS;
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = ADDR_W - IDX_W;

  typedef struct packed {
    logic              refBit;
    logic              valid;
    logic [TAG_W-1:0]  tag;
    logic [DATA_W-1:0] data;
  } wayEntry_t;

  localparam int ENTRY_W = $bits(wayEntry_t);

  typedef struct packed {
    logic capture;  // accept request, read both ways
    logic update;   // response cycle, write both ways back
  } ctrlStrobe_t;
endpackage

// File: rtl/assoc_way_array.sv
module assoc_way_array #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             en,
  input  logic             we,
  input  logic [AW-1:0]    addr,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      rdata <= '0;
    end else if (en) begin
      if (we) mem[addr] <= wdata;
      else    rdata     <= mem[addr];
    end
  end
endmodule

// File: rtl/assoc_cache_ctrl.sv
module assoc_cache_ctrl
  import assoc_cache_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  output logic        reqReady,
  output logic        respValid,
  output ctrlStrobe_t strobe
);
  typedef enum logic {ST_IDLE, ST_RESP} ctrlState_t;
  ctrlState_t state;

  always_ff @(posedge clk) begin
    if (!rstN)                     state <= ST_IDLE;
    else if (state == ST_RESP)     state <= ST_IDLE;
    else if (reqValid)             state <= ST_RESP;
  end

  always_comb begin
    reqReady       = (state == ST_IDLE);
    respValid      = (state == ST_RESP);
    strobe.capture = reqReady && reqValid;
    strobe.update  = (state == ST_RESP);
  end

  // R2
  resp_follows_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> respValid);
  // R2
  resp_single_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    respValid |=> (!respValid && reqReady));
endmodule

// File: rtl/assoc_cache_dpath.sv
module assoc_cache_dpath
  import assoc_cache_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic              respValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] memData,
  output logic              respHit,
  output logic [DATA_W-1:0] respData,
  output logic              memRead,
  output logic [ADDR_W-1:0] memAddr
);
  logic [ADDR_W-1:0] addrQ;
  logic [IDX_W-1:0]  setIdx;
  logic [TAG_W-1:0]  tagQ;
  wayEntry_t         rdEntry [WAYS];
  wayEntry_t         wrEntry [WAYS];
  logic [WAYS-1:0]   wayHit;
  logic              hitAny;
  logic              hitWay;
  logic              victimWay;
  logic              useWay;

  always_ff @(posedge clk) begin
    if (!rstN)               addrQ <= '0;
    else if (strobe.capture) addrQ <= reqAddr;
  end

  assign tagQ   = addrQ[ADDR_W-1:IDX_W];
  assign setIdx = strobe.capture ? reqAddr[IDX_W-1:0] : addrQ[IDX_W-1:0];

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [ENTRY_W-1:0] rdRaw;
    assoc_way_array #(.DEPTH(SETS), .WIDTH(ENTRY_W)) u_array (
      .clk  (clk),
      .rstN (rstN),
      .en   (strobe.capture || strobe.update),
      .we   (strobe.update),
      .addr (setIdx),
      .wdata(wrEntry[w]),
      .rdata(rdRaw)
    );
    assign rdEntry[w] = wayEntry_t'(rdRaw);
    assign wayHit[w]  = rdEntry[w].valid && (rdEntry[w].tag == tagQ);

    always_comb begin
      wrEntry[w] = rdEntry[w];
      if (useWay == 1'(w)) begin
        wrEntry[w].refBit = 1'b1;
        wrEntry[w].valid  = 1'b1;
        wrEntry[w].tag    = tagQ;
        wrEntry[w].data   = hitAny ? rdEntry[w].data : memData;
      end else begin
        wrEntry[w].refBit = 1'b0;
      end
    end
  end

  always_comb begin
    hitAny = |wayHit;
    hitWay = wayHit[1];
    if (!rdEntry[0].valid)      victimWay = 1'b0;
    else if (!rdEntry[1].valid) victimWay = 1'b1;
    else                        victimWay = rdEntry[0].refBit;
    useWay   = hitAny ? hitWay : victimWay;
    respHit  = strobe.update && hitAny;
    respData = hitAny ? rdEntry[hitWay].data : memData;
    memRead  = strobe.update && !hitAny;
    memAddr  = addrQ;
  end

  // R3
  single_way_hit_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.update |-> $onehot0(wayHit));
  // R8
  mem_read_in_resp_chk: assert property (@(posedge clk) disable iff (!rstN)
    memRead |-> respValid);
  // R6
  ref_bits_differ_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.update && wrEntry[0].valid && wrEntry[1].valid)
      |-> (wrEntry[0].refBit != wrEntry[1].refBit));
endmodule

// File: rtl/assoc_cache.sv
module assoc_cache
  import assoc_cache_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic              reqReady,
  output logic              respValid,
  output logic              respHit,
  output logic [DATA_W-1:0] respData,
  output logic              memRead,
  output logic [ADDR_W-1:0] memAddr,
  input  logic [DATA_W-1:0] memData
);
  ctrlStrobe_t strobe;

  assoc_cache_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqReady (reqReady),
    .respValid(respValid),
    .strobe   (strobe)
  );

  assoc_cache_dpath u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .respValid(respValid),
    .reqAddr  (reqAddr),
    .memData  (memData),
    .respHit  (respHit),
    .respData (respData),
    .memRead  (memRead),
    .memAddr  (memAddr)
  );
endmodule

// File: tb/assoc_cache_bench.sv
module assoc_cache_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       reqValid = 1'b0;
  logic [6:0] reqAddr = '0;
  logic       reqReady, respValid, respHit, memRead;
  logic [1:0] respData, memData;
  logic [6:0] memAddr;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int lruList [8][$];  // per set: tags, most recent first

  always #2.5 clk = ~clk;

  function automatic logic [1:0] romWord(logic [6:0] a);
    return a[1:0] ^ a[4:3] ^ {a[6], a[5]};
  endfunction

  assign memData = romWord(memAddr);

  assoc_cache u_assoc_cache (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqReady(reqReady), .respValid(respValid), .respHit(respHit),
    .respData(respData), .memRead(memRead), .memAddr(memAddr),
    .memData(memData)
  );

  task automatic check(string req, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic bit modelAccess(logic [6:0] a);
    int s = int'(a[2:0]);
    int t = int'(a[6:3]);
    int pos = -1;
    foreach (lruList[s][i]) if (lruList[s][i] == t) pos = i;
    if (pos >= 0) begin
      lruList[s].delete(pos);
      lruList[s].push_front(t);
      return 1'b1;
    end
    lruList[s].push_front(t);
    if (lruList[s].size() > 2) void'(lruList[s].pop_back());
    return 1'b0;
  endfunction

  task automatic access(logic [6:0] a, string req);
    bit expHit;
    @(negedge clk);
    check("R2", reqReady, 1, "ready before request");
    check("R8", memRead, 0, "memRead idle");
    reqValid = 1'b1;
    reqAddr  = a;
    expHit   = modelAccess(a);
    @(negedge clk);
    reqValid = 1'b0;
    check("R2", respValid, 1, "respValid in response cycle");
    check("R2", reqReady, 0, "ready low in response cycle");
    check(req, respHit, int'(expHit), $sformatf("hit for addr %0d", a));
    check("R3", respData, int'(romWord(a)), $sformatf("data for addr %0d", a));
    check(expHit ? "R8" : "R4", memRead, int'(!expHit), "memRead");
    if (!expHit) check("R4", memAddr, int'(a), "memAddr on miss");
    @(negedge clk);
    check("R2", respValid, 0, "respValid one cycle only");
    check("R2", reqReady, 1, "ready after response");
  endtask

  initial begin
    for (int c = 0; c < 50000; c++) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int seed = 17;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1", reqReady, 1, "reqReady after reset");
    check("R1", respValid, 0, "respValid after reset");
    check("R1", memRead, 0, "memRead after reset");
    // set 3: tags 0,1,2 ; set 5 interleaved
    access(7'h03, "R1");  // tag0 miss
    access(7'h0B, "R5");  // tag1 miss, fills second way
    access(7'h05, "R9");  // other set
    access(7'h03, "R5");  // tag0 hit
    access(7'h0B, "R5");  // tag1 hit
    access(7'h03, "R7");  // hit refreshes tag0
    access(7'h13, "R7");  // tag2 miss evicts tag1
    access(7'h03, "R7");  // tag0 still hits
    access(7'h0B, "R6");  // tag1 miss, evicts tag2
    access(7'h13, "R6");  // tag2 miss, evicts tag0
    access(7'h05, "R9");  // other set untouched
    for (int n = 0; n < 400; n++) begin
      seed = (seed * 1103515245 + 12345) & 32'h7fffffff;
      access({2'b00, seed[12:11], 1'b0, seed[9:8]}, "R6");
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule